// File: doc/BRIEF.md
# Tick Timer with Mode Control

This block is a free-running 32-bit tick counter paired with a mode word. Software programs the mode word to pick an operating mode, set a match period, enable the interrupt and acknowledge a pending event. Software can also read the live count or load a new one. When the low part of the count reaches the programmed period, the timer flags a pending event. Depending on the mode, it then restarts from zero, freezes, or keeps counting.

Both registers share one write port that carries a select bit. A single read port returns whichever register the read select points at. The interrupt line is high while the pending flag and the enable flag are both set. A software write to either register stalls counting for that cycle. The match is evaluated against the freshly written settings from the following cycle.

Top module: `tickTimer`

## Requirements
- R1: After reset the count reads 0, the mode word reads 0 and the interrupt output is low.
- R2: Mode word layout: bits [31:30] select the mode (00 off, 01 restart, 10 one-shot, 11 free-run), bit 29 enables the interrupt, bit 28 is the pending flag, and bits [27:0] hold the match period. A write select of 0 addresses the mode word and 1 addresses the count. The read select uses the same coding.
- R3: A mode word write that changes the mode field to restart, one-shot or free-run starts counting. After that, the count increases by one on every cycle with no register write.
- R4: A mode word write that changes the mode field to off stops counting. A mode word write that leaves the mode field unchanged leaves the counter's running or stopped state as it was.
- R5: While counting, a cycle in which the low 28 bits of the count equal the period, and no register write occurs, sets the pending flag.
- R6: In restart mode, the count reads 0 on the cycle after a match and counts up again from there.
- R7: In one-shot mode, counting stops on a match and the count holds the period value.
- R8: In free-run mode, the count keeps incrementing through a match.
- R9: On a mode word write, a 0 in bit 28 clears the pending flag. A 1 there keeps the flag's previous value and never sets it.
- R10: The interrupt output is high exactly while the pending flag and the enable bit are both set. Clearing the pending flag drops it.
- R11: A count write loads the written value, taking priority over the increment in that cycle. The count read returns the live count.
- R12: In any cycle with a register write, the count does not advance and no match is taken. From the next cycle, the comparison uses the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 mode word, 1 count |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 mode word, 1 count |
| rdData | output | 32 | Selected register value |
| timerIrq | output | 1 | Timer interrupt request |

## Verification
The counter is driven in each of its four modes with small periods, so that every match happens within a few cycles of a known start point. Restart, one-shot and free-run are told apart by reading the count on the cycles just after a match. The pending flag is written with both 0 and 1, while set and while clear, which separates the keep rule from a plain store. Back-to-back count and mode writes on a running counter expose the load priority and the one-cycle stall of a write.

// File: rtl/tickTimerPkg.sv
package tickTimerPkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_FREE    = 2'b11
  } tmode_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic inc;
  } cntStrobe_t;

  localparam logic SEL_MODE  = 1'b0;
  localparam logic SEL_COUNT = 1'b1;

endpackage

// File: rtl/ttCount.sv
module ttCount
  import tickTimerPkg::*;
#(
  parameter int REG_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [REG_W-1:0] loadVal,
  input  logic [PER_W-1:0] period,
  output logic [REG_W-1:0] countOut,
  output logic             cmpEq
);

  logic [REG_W-1:0] cntQ;

  // load beats clear beats increment
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= loadVal;
    end else if (strobe.clear) begin
      cntQ <= '0;
    end else if (strobe.inc) begin
      cntQ <= cntQ + REG_W'(1);
    end
  end

  assign cmpEq    = (cntQ[PER_W-1:0] == period);
  assign countOut = cntQ;

endmodule

// File: rtl/ttCtrl.sv
module ttCtrl
  import tickTimerPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic             cmpEq,
  output cntStrobe_t       strobe,
  output logic [REG_W-1:0] modeWord,
  output logic [REG_W-5:0] periodOut,
  output logic             irq
);

  localparam int MODE_LSB = REG_W - 2;
  localparam int IE_POS   = REG_W - 3;
  localparam int IP_POS   = REG_W - 4;
  localparam int PER_W    = REG_W - 4;

  tmode_e           modeQ;
  logic             ieQ;
  logic             ipQ;
  logic             runQ;
  logic [PER_W-1:0] perQ;

  logic   wrMode;
  logic   wrCnt;
  logic   hit;
  tmode_e modeNew;

  assign wrMode  = wrEn && (wrSel == SEL_MODE);
  assign wrCnt   = wrEn && (wrSel == SEL_COUNT);
  assign modeNew = tmode_e'(wrData[REG_W-1:MODE_LSB]);
  // a write cycle never takes a match; the new settings are compared next cycle
  assign hit     = runQ && cmpEq && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
      ieQ   <= 1'b0;
      ipQ   <= 1'b0;
      runQ  <= 1'b0;
      perQ  <= '0;
    end else if (wrMode) begin
      modeQ <= modeNew;
      ieQ   <= wrData[IE_POS];
      perQ  <= wrData[PER_W-1:0];
      ipQ   <= wrData[IP_POS] ? ipQ : 1'b0;
      if (modeNew != modeQ) begin
        runQ <= (modeNew != MODE_OFF);
      end
    end else if (hit) begin
      ipQ <= 1'b1;
      if (modeQ == MODE_ONESHOT) begin
        runQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.load  = wrCnt;
    strobe.clear = hit && (modeQ == MODE_RESTART);
    strobe.inc   = runQ && !wrEn && !(hit && (modeQ != MODE_FREE));
  end

  assign modeWord  = {modeQ, ieQ, ipQ, perQ};
  assign periodOut = perQ;
  assign irq       = ipQ && ieQ;

endmodule

// File: rtl/tickTimer.sv
module tickTimer
  import tickTimerPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdSel,
  output logic [REG_W-1:0] rdData,
  output logic             timerIrq
);

  localparam int PER_W = REG_W - 4;

  cntStrobe_t       strobe;
  logic             cmpEq;
  logic [REG_W-1:0] cntVal;
  logic [REG_W-1:0] modeWord;
  logic [PER_W-1:0] period;

  ttCtrl #(.REG_W(REG_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .cmpEq    (cmpEq),
    .strobe   (strobe),
    .modeWord (modeWord),
    .periodOut(period),
    .irq      (timerIrq)
  );

  ttCount #(.REG_W(REG_W), .PER_W(PER_W)) uCount (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (wrData),
    .period  (period),
    .countOut(cntVal),
    .cmpEq   (cmpEq)
  );

  assign rdData = (rdSel == SEL_COUNT) ? cntVal : modeWord;

endmodule

// File: rtl/ttChecker.sv
module ttChecker
  import tickTimerPkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] cntVal,
  input logic [REG_W-1:0] modeWord,
  input logic             timerIrq
);

  localparam int MODE_LSB = REG_W - 2;
  localparam int IP_POS   = REG_W - 4;
  localparam int PER_W    = REG_W - 4;

  logic [1:0] modeF;
  logic       atPeriod;
  assign modeF    = modeWord[REG_W-1:MODE_LSB];
  assign atPeriod = (cntVal[PER_W-1:0] == modeWord[PER_W-1:0]);

  assert_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_COUNT) |=> (cntVal == $past(wrData)));

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_MODE) |=> $stable(cntVal));

  assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == MODE_OFF && !wrEn) |=> $stable(cntVal));

  assert_oneshot_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == MODE_ONESHOT && !wrEn && atPeriod) |=> $stable(cntVal));

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == MODE_RESTART && !wrEn && atPeriod) |=> (cntVal == '0));

  assert_ip_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_MODE && wrData[IP_POS])
      |=> (modeWord[IP_POS] == $past(modeWord[IP_POS])));

  assert_ip_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_MODE && !wrData[IP_POS]) |=> !modeWord[IP_POS]);

  assert_irq_needs_ip_R10: assert property (@(posedge clk) disable iff (!rstN)
    !modeWord[IP_POS] |-> !timerIrq);

endmodule

bind tickTimer ttChecker #(.REG_W(REG_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .cntVal  (cntVal),
  .modeWord(modeWord),
  .timerIrq(timerIrq)
);

// File: tb/tb_tickTimer.sv
module tb_tickTimer;

  localparam int K_CNT  = 0;
  localparam int K_MODE = 1;
  localparam int K_IRQ  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        timerIrq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];

  tickTimer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .timerIrq(timerIrq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mw(input logic [1:0] m, input logic ie,
                                     input logic ip, input logic [27:0] per);
    return {m, ie, ip, per};
  endfunction

  task automatic push(input int dly, input int kind, input logic [31:0] v, input string tag);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares due items against the design's outputs
  initial begin
    forever begin
      @(negedge clk);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due <= cyc) begin
          logic [31:0] act;
          if (q[i].kind == K_IRQ) begin
            act = {31'd0, timerIrq};
          end else begin
            rdSel = (q[i].kind == K_CNT);
            #1;
            act = rdData;
          end
          total++;
          if (q[i].due != cyc || act !== q[i].exp) begin
            bad++;
            $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                     q[i].tag, q[i].kind, cyc, act, q[i].exp);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    push(1, K_CNT, 32'd0, "R1");
    push(1, K_MODE, 32'd0, "R1");
    push(1, K_IRQ, 32'd0, "R1");
    idle(2);

    // restart mode, period 5, irq enabled (R2 encodings)
    wr(1'b0, mw(2'b01, 1'b1, 1'b0, 28'd5));
    push(3, K_CNT, 32'd3, "R3");
    push(5, K_CNT, 32'd5, "R5");
    push(6, K_CNT, 32'd0, "R6");
    push(6, K_MODE, 32'h7000_0005, "R5");
    push(6, K_IRQ, 32'd1, "R10");
    push(7, K_CNT, 32'd1, "R6");
    idle(8);

    // switch off keeping pending (R4, R9)
    wr(1'b0, mw(2'b00, 1'b1, 1'b1, 28'd5));
    push(1, K_MODE, 32'h3000_0005, "R9");
    push(1, K_IRQ, 32'd1, "R10");
    wr(1'b1, 32'd40);
    push(1, K_CNT, 32'd40, "R11");
    push(4, K_CNT, 32'd40, "R4");
    idle(5);

    // clear pending, then a one must not set it
    wr(1'b0, mw(2'b00, 1'b1, 1'b0, 28'd5));
    push(1, K_MODE, 32'h2000_0005, "R9");
    push(1, K_IRQ, 32'd0, "R10");
    idle(2);
    wr(1'b0, mw(2'b00, 1'b1, 1'b1, 28'd5));
    push(1, K_MODE, 32'h2000_0005, "R9");
    idle(2);

    // one-shot, period 4, irq disabled
    wr(1'b1, 32'd0);
    wr(1'b0, mw(2'b10, 1'b0, 1'b0, 28'd4));
    push(4, K_CNT, 32'd4, "R3");
    push(5, K_CNT, 32'd4, "R7");
    push(8, K_CNT, 32'd4, "R7");
    push(6, K_MODE, 32'h9000_0004, "R5");
    push(6, K_IRQ, 32'd0, "R10");
    idle(9);
    // same mode again: stays stopped, pending kept
    wr(1'b0, mw(2'b10, 1'b0, 1'b1, 28'd9));
    push(1, K_MODE, 32'h9000_0009, "R9");
    push(3, K_CNT, 32'd4, "R4");
    idle(4);

    // free-run, period 3
    wr(1'b1, 32'd0);
    wr(1'b0, mw(2'b11, 1'b0, 1'b0, 28'd3));
    push(3, K_CNT, 32'd3, "R8");
    push(5, K_MODE, 32'hD000_0003, "R5");
    push(6, K_CNT, 32'd6, "R8");
    idle(7);

    // load on a running counter, then a stalling mode write
    wr(1'b1, 32'd1000);
    push(1, K_CNT, 32'd1001, "R11");
    wr(1'b0, mw(2'b11, 1'b0, 1'b0, 28'd3));
    push(1, K_CNT, 32'd1002, "R12");
    push(1, K_MODE, 32'hC000_0003, "R9");
    idle(4);

    foreach (q[i]) begin
      total++; bad++;
      $display("FAIL %s actual=unchecked expected=%h", q[i].tag, q[i].exp);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule